// File: doc/BRIEF.md
# Fractional-N Dual-Modulus Divider Sequencer

This block sets the average division ratio of a fractional-N synthesizer loop. It has two parts. A feedback counter divides a fast clock by either P or P−1. A sequencer decides, once per reference period, which of the two moduli the counter uses next. The sequencer spreads the P periods evenly over a repeating pattern of QP + QM reference periods, where QP periods use P and QM periods use P−1. The long-run ratio is therefore (QP·P + QM·(P−1)) / (QP + QM), which is any rational value from P−1 to P.

The surrounding loop supplies a one-cycle reference strobe in the fast clock domain, along with the three ratio settings. New settings are taken only where a pattern ends, so a pattern is never split between two configurations. The block also drives a gate for the downstream phase detector: while the gate is high, that detector must issue no pump pulses. A separate flag reports whether the settings are usable. To produce it, the block compares a precomputed oscillator frequency estimate against the allowed oscillator band.

Top module: `fracn_mod_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `mod_hi`=0, `div_clk`=0 and `pd_gate`=1, and the active configuration is loaded from the inputs.
- R2: After reset, `pd_gate` stays 1 until the first `ref_tick`. It drops to 0 on the edge that samples that tick if the active configuration is usable.
- R3: With a usable configuration and T = QP + QM, number the ticks of a pattern j = 1..T. On the edge that samples tick j, `mod_hi` becomes 1 exactly when floor(j·QP/T) > floor((j−1)·QP/T), and becomes 0 otherwise. `mod_hi` does not change on edges without a tick.
- R4: The internal pattern accumulator stays strictly below T while the configuration is usable.
- R5: Each period of `div_clk` runs from one rising edge to the next. Its length is P fast-clock cycles if `mod_hi` was 1 on the edge that started the period, and P−1 cycles if it was 0.
- R6: In a period of N cycles, `div_clk` is high for N − floor(N/2) cycles.
- R7: New values of `cfg_p`, `cfg_q_hi` and `cfg_q_lo` become active only after the tick that ends a pattern (j = T). Ticks before that follow the old pattern.
- R8: A configuration with P < 2 or with QP + QM = 0 is unusable. While it is active, every tick leaves `pd_gate`=1 and `mod_hi`=0, and every tick loads the inputs.
- R9: One clock after the inputs are applied, `cfg_ok` is 1 exactly when P ≥ 2, QP + QM ≠ 0 and 540 < `vco_est_mhz` < 729.
- R10: QP = 0 gives `mod_hi`=0 on every tick. QM = 0 gives `mod_hi`=1 on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (oscillator output) |
| rst | input | 1 | Synchronous reset, active high |
| ref_tick | input | 1 | One-cycle strobe marking a reference edge |
| cfg_p | input | PW | Integer modulus P |
| cfg_q_hi | input | QW | Reference periods per pattern that divide by P |
| cfg_q_lo | input | QW | Reference periods per pattern that divide by P−1 |
| vco_est_mhz | input | FW | Precomputed reference × ratio product, in MHz |
| div_clk | output | 1 | Divided feedback clock |
| mod_hi | output | 1 | Modulus select: 1 selects P, 0 selects P−1 |
| pd_gate | output | 1 | Phase detector gate, active high |
| cfg_ok | output | 1 | Configuration and oscillator band check passed |

## Verification
`mod_hi` and `pd_gate` are due on the edge that samples `ref_tick`. The bench raises the strobe just after one falling edge and reads both outputs at the next falling edge. `cfg_ok` is due on the edge after the inputs change, so it is read one falling edge after they are driven. A divider period starts on the edge after a terminal count. The bench timestamps each rising edge of `div_clk` at a falling edge, and pairs it with the `mod_hi` value seen one falling edge earlier, which is the value the reload used.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

  // total reference periods in one pattern
  function automatic int unsigned tot_periods(input int unsigned q_hi,
                                              input int unsigned q_lo);
    return q_hi + q_lo;
  endfunction

  // a configuration can run only with a real modulus pair and a non-empty pattern
  function automatic bit cfg_usable(input int unsigned p,
                                    input int unsigned tot);
    return (p >= 2) && (tot != 0);
  endfunction

  // divider length for one feedback period; never below one cycle
  function automatic int unsigned mod_len(input int unsigned p, input bit hi);
    if (p < 2) return 1;
    return hi ? p : p - 1;
  endfunction

  // strict band test for the oscillator estimate
  function automatic bit in_band(input int unsigned v,
                                 input int unsigned lo,
                                 input int unsigned hi);
    return (v > lo) && (v < hi);
  endfunction

  // accumulator overflow test: adding q_hi reaches the pattern length
  function automatic bit acc_wraps(input int unsigned acc,
                                   input int unsigned q_hi,
                                   input int unsigned tot);
    return (acc + q_hi) >= tot;
  endfunction

  // accumulator value after one reference period, modulo the pattern length
  function automatic int unsigned acc_step(input int unsigned acc,
                                           input int unsigned q_hi,
                                           input int unsigned tot);
    int unsigned s;
    s = acc + q_hi;
    return (s >= tot) ? s - tot : s;
  endfunction

endpackage

// File: rtl/fracn_cfg_shadow.sv
module fracn_cfg_shadow
  import fracn_pkg::*;
#(
  parameter int PW         = 8,
  parameter int QW         = 8,
  parameter int FW         = 12,
  parameter int VCO_LO_MHZ = 540,
  parameter int VCO_HI_MHZ = 729
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [PW-1:0] in_p,
  input  logic [QW-1:0] in_q_hi,
  input  logic [QW-1:0] in_q_lo,
  input  logic [FW-1:0] in_vco,
  output logic [PW-1:0] p_act,
  output logic [QW-1:0] qh_act,
  output logic [QW:0]   tot_act,
  output logic          act_valid,
  output logic          ok_q
);
  localparam int TW = QW + 1;

  logic [TW-1:0] in_tot;
  logic          in_ok;

  assign in_tot = TW'(tot_periods(32'(in_q_hi), 32'(in_q_lo)));
  assign in_ok  = cfg_usable(32'(in_p), 32'(in_tot)) &&
                  in_band(32'(in_vco), VCO_LO_MHZ, VCO_HI_MHZ);

  // active copy of the ratio settings
  always_ff @(posedge clk) begin
    if (load) begin
      p_act   <= in_p;
      qh_act  <= in_q_hi;
      tot_act <= in_tot;
    end
  end

  // registered usability flag for the pending inputs
  always_ff @(posedge clk) begin
    if (rst) ok_q <= 1'b0;
    else     ok_q <= in_ok;
  end

  assign act_valid = cfg_usable(32'(p_act), 32'(tot_act));

endmodule

// File: rtl/fracn_pattern_acc.sv
module fracn_pattern_acc
  import fracn_pkg::*;
#(
  parameter int QW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          act_valid,
  input  logic [QW-1:0] qh_act,
  input  logic [QW:0]   tot_act,
  output logic [QW:0]   acc_q,
  output logic          wrap,
  output logic          pat_end,
  output logic          sel_q,
  output logic          gate_q
);
  localparam int TW = QW + 1;

  logic [TW-1:0] step_q;
  logic [TW-1:0] acc_nx;
  logic [TW-1:0] last_step;

  assign wrap      = acc_wraps(32'(acc_q), 32'(qh_act), 32'(tot_act));
  assign acc_nx    = TW'(acc_step(32'(acc_q), 32'(qh_act), 32'(tot_act)));
  assign last_step = tot_act - TW'(1);
  assign pat_end   = act_valid && (step_q == last_step);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      step_q <= '0;
      sel_q  <= 1'b0;
      gate_q <= 1'b1;
    end else if (tick) begin
      if (!act_valid) begin
        acc_q  <= '0;
        step_q <= '0;
        sel_q  <= 1'b0;
        gate_q <= 1'b1;
      end else begin
        sel_q  <= wrap;
        gate_q <= 1'b0;
        if (pat_end) begin
          acc_q  <= '0;
          step_q <= '0;
        end else begin
          acc_q  <= acc_nx;
          step_q <= step_q + TW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/fracn_dual_mod_div.sv
module fracn_dual_mod_div
  import fracn_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] p_act,
  input  logic          sel,
  output logic          div_q,
  output logic          term
);
  logic [PW-1:0] cnt_q, cnt_nx;
  logic [PW-1:0] half_q, half_nx;
  logic [PW-1:0] len;

  assign len     = PW'(mod_len(32'(p_act), sel));
  assign term    = (cnt_q == '0);
  assign cnt_nx  = term ? len - PW'(1) : cnt_q - PW'(1);
  assign half_nx = term ? (len >> 1) : half_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      half_q <= '0;
      div_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      half_q <= half_nx;
      div_q  <= (cnt_nx >= half_nx);
    end
  end

endmodule

// File: rtl/fracn_mod_seq.sv
module fracn_mod_seq
  import fracn_pkg::*;
#(
  parameter int PW         = 8,
  parameter int QW         = 8,
  parameter int FW         = 12,
  parameter int VCO_LO_MHZ = 540,
  parameter int VCO_HI_MHZ = 729
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_tick,
  input  logic [PW-1:0] cfg_p,
  input  logic [QW-1:0] cfg_q_hi,
  input  logic [QW-1:0] cfg_q_lo,
  input  logic [FW-1:0] vco_est_mhz,
  output logic          div_clk,
  output logic          mod_hi,
  output logic          pd_gate,
  output logic          cfg_ok
);
  localparam int TW = QW + 1;

  logic [PW-1:0] p_act;
  logic [QW-1:0] qh_act;
  logic [TW-1:0] tot_q;
  logic [TW-1:0] acc_q;
  logic          act_valid;
  logic          cfg_load;
  logic          seq_wrap;
  logic          pat_end;
  logic          div_term;

  // settings move in on reset, at a pattern end, or on any tick while unusable
  assign cfg_load = rst | (ref_tick & (~act_valid | pat_end));

  fracn_cfg_shadow #(
    .PW(PW), .QW(QW), .FW(FW),
    .VCO_LO_MHZ(VCO_LO_MHZ), .VCO_HI_MHZ(VCO_HI_MHZ)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .load     (cfg_load),
    .in_p     (cfg_p),
    .in_q_hi  (cfg_q_hi),
    .in_q_lo  (cfg_q_lo),
    .in_vco   (vco_est_mhz),
    .p_act    (p_act),
    .qh_act   (qh_act),
    .tot_act  (tot_q),
    .act_valid(act_valid),
    .ok_q     (cfg_ok)
  );

  fracn_pattern_acc #(.QW(QW)) u_pat (
    .clk      (clk),
    .rst      (rst),
    .tick     (ref_tick),
    .act_valid(act_valid),
    .qh_act   (qh_act),
    .tot_act  (tot_q),
    .acc_q    (acc_q),
    .wrap     (seq_wrap),
    .pat_end  (pat_end),
    .sel_q    (mod_hi),
    .gate_q   (pd_gate)
  );

  fracn_dual_mod_div #(.PW(PW)) u_div (
    .clk  (clk),
    .rst  (rst),
    .p_act(p_act),
    .sel  (mod_hi),
    .div_q(div_clk),
    .term (div_term)
  );

endmodule

// File: rtl/fracn_mod_seq_chk.sv
module fracn_mod_seq_chk #(
  parameter int PW = 8,
  parameter int QW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ref_tick,
  input logic          mod_hi,
  input logic          pd_gate,
  input logic          div_clk,
  input logic [QW:0]   acc_q,
  input logic [QW:0]   tot_q,
  input logic          act_valid,
  input logic          seq_wrap,
  input logic          cfg_load,
  input logic          div_term,
  input logic [PW-1:0] p_act
);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (pd_gate && !mod_hi && !div_clk)); // R1

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ref_tick |=> $stable(mod_hi)); // R3

  AST_WRAP_SELECTS_P: assert property (@(posedge clk) disable iff (rst)
    (ref_tick && act_valid && seq_wrap) |=> mod_hi); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    act_valid |-> (acc_q < tot_q)); // R4

  AST_RELOAD_RISE: assert property (@(posedge clk) disable iff (rst)
    div_term |=> div_clk); // R5

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> $stable(p_act)); // R7

  AST_UNUSABLE_GATED: assert property (@(posedge clk) disable iff (rst)
    (ref_tick && !act_valid) |=> (pd_gate && !mod_hi)); // R8

endmodule

bind fracn_mod_seq fracn_mod_seq_chk #(.PW(PW), .QW(QW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ref_tick (ref_tick),
  .mod_hi   (mod_hi),
  .pd_gate  (pd_gate),
  .div_clk  (div_clk),
  .acc_q    (acc_q),
  .tot_q    (tot_q),
  .act_valid(act_valid),
  .seq_wrap (seq_wrap),
  .cfg_load (cfg_load),
  .div_term (div_term),
  .p_act    (p_act)
);

// File: tb/tb_fracn_mod_seq.sv
module tb_fracn_mod_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8, QW = 8, FW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ref_tick = 1'b0;
  logic [PW-1:0] cfg_p = 8'd4;
  logic [QW-1:0] cfg_q_hi = 8'd2;
  logic [QW-1:0] cfg_q_lo = 8'd1;
  logic [FW-1:0] vco_est_mhz = 12'd600;
  logic          div_clk, mod_hi, pd_gate, cfg_ok;

  int checks = 0;
  int errors = 0;

  // bench model of the active settings and the position in the pattern
  int unsigned m_p, m_qh, m_tot, m_j;

  // divider monitor state
  bit div_en = 1'b0;
  bit have_rise = 1'b0;
  bit prev_div = 1'b0, prev_mod = 1'b0, rise_sel = 1'b0;
  int cyc = 0, last_rise = 0, high_cnt = 0;

  fracn_mod_seq dut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .cfg_p(cfg_p),
    .cfg_q_hi(cfg_q_hi), .cfg_q_lo(cfg_q_lo), .vco_est_mhz(vco_est_mhz),
    .div_clk(div_clk), .mod_hi(mod_hi), .pd_gate(pd_gate), .cfg_ok(cfg_ok)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_sel(int unsigned j, int unsigned qh, int unsigned tot);
    return ((j * qh) / tot) != (((j - 1) * qh) / tot);
  endfunction

  function automatic bit exp_usable(int unsigned p, int unsigned tot);
    return (p >= 2) && (tot != 0);
  endfunction

  function automatic bit exp_ok(int unsigned p, int unsigned qh, int unsigned ql, int unsigned v);
    return exp_usable(p, qh + ql) && (v > 540) && (v < 729);
  endfunction

  task automatic model_load();
    m_p = cfg_p; m_qh = cfg_q_hi; m_tot = cfg_q_hi + cfg_q_lo; m_j = 0;
  endtask

  // one reference strobe; returns the observed select
  task automatic do_tick(input int gap, output bit got);
    bit es, eg, ok;
    repeat (gap) @(negedge clk);
    ok = exp_usable(m_p, m_tot);
    es = ok ? exp_sel(m_j + 1, m_qh, m_tot) : 1'b0;
    eg = !ok;
    if (!ok || (m_j + 1 == m_tot)) model_load();
    else m_j++;
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
    got = mod_hi;
    check(mod_hi == es, ok ? "R3 pattern select" : "R8 select while unusable", mod_hi, es);
    check(pd_gate == eg, ok ? "R2 gate after tick" : "R8 gate while unusable", pd_gate, eg);
  endtask

  // divider period and duty monitor (R5, R6)
  always @(negedge clk) begin
    if (rst || !div_en) begin
      have_rise = 1'b0;
    end else begin
      if (div_clk && !prev_div) begin
        if (have_rise) begin
          int n;
          n = rise_sel ? int'(m_p) : int'(m_p) - 1;
          check(cyc - last_rise == n, "R5 divider period", cyc - last_rise, n);
          check(high_cnt == n - n / 2, "R6 divider high time", high_cnt, n - n / 2);
        end
        have_rise = 1'b1;
        last_rise = cyc;
        rise_sel  = prev_mod;
        high_cnt  = 0;
      end
      if (div_clk) high_cnt++;
    end
    prev_div = div_clk;
    prev_mod = mod_hi;
    cyc++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit g;
    int ones;
    bit lit[5];
    int unsigned r;
    r = $urandom(32'd20240611);

    // R1: reset state
    repeat (3) @(negedge clk);
    check(mod_hi == 1'b0, "R1 reset mod_hi", mod_hi, 0);
    check(div_clk == 1'b0, "R1 reset div_clk", div_clk, 0);
    check(pd_gate == 1'b1, "R1 reset pd_gate", pd_gate, 1);
    model_load();
    rst = 1'b0;
    div_en = 1'b1;
    repeat (12) @(negedge clk);
    check(pd_gate == 1'b1, "R2 gate held before first tick", pd_gate, 1);

    // R3: ratio 3 2/3, pattern from a fresh start is 0,1,1
    ones = 0;
    for (int k = 0; k < 6; k++) begin
      do_tick(9, g);
      if (k < 3) ones += int'(g);
      if (k == 0) check(pd_gate == 1'b0, "R2 gate clears on first tick", pd_gate, 0);
    end
    check(ones == 2, "R3 two P periods in three", ones, 2);

    // R7: change mid-pattern, old pattern finishes first
    lit = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
    do_tick(7, g);
    cfg_q_hi = 8'd1; cfg_q_lo = 8'd2;
    for (int k = 0; k < 5; k++) begin
      do_tick(6, g);
      check(g == lit[k], "R7 boundary-aligned update", g, lit[k]);
    end

    // R10: extreme settings
    cfg_q_hi = 8'd0; cfg_q_lo = 8'd5;
    for (int k = 0; k < 3; k++) do_tick(5, g);
    cfg_q_hi = 8'd5; cfg_q_lo = 8'd0;
    for (int k = 0; k < 5; k++) begin
      do_tick(5, g);
      check(g == 1'b0, "R10 QP zero gives P-1 only", g, 0);
    end
    for (int k = 0; k < 5; k++) begin
      do_tick(5, g);
      check(g == 1'b1, "R10 QM zero gives P only", g, 1);
    end

    // random ratios with fixed P (R3, R4, R5, R8 via empty patterns)
    for (int k = 0; k < 80; k++) begin
      if ($urandom_range(0, 9) < 3) begin
        cfg_q_hi = 8'($urandom_range(0, 6));
        cfg_q_lo = 8'($urandom_range(0, 6));
      end
      do_tick(int'($urandom_range(1, 25)), g);
    end

    // R8: unusable modulus
    div_en = 1'b0;
    cfg_p = 8'd1; cfg_q_hi = 8'd3; cfg_q_lo = 8'd2;
    for (int k = 0; k < 20 && m_p != 1; k++) do_tick(4, g);
    check(m_p == 1, "R8 unusable setting reached", int'(m_p), 1);
    for (int k = 0; k < 3; k++) begin
      do_tick(4, g);
      check(pd_gate == 1'b1 && g == 1'b0, "R8 gated while unusable", pd_gate, 1);
    end
    cfg_p = 8'd4; cfg_q_hi = 8'd2; cfg_q_lo = 8'd1;
    do_tick(4, g);
    check(pd_gate == 1'b1, "R8 recovery tick still gated", pd_gate, 1);
    do_tick(4, g);
    check(pd_gate == 1'b0, "R8 gate released after recovery", pd_gate, 0);

    // R9: band and setting check
    begin
      int unsigned cp[8] = '{4, 4, 4, 4, 4, 1, 2, 4};
      int unsigned ch[8] = '{2, 2, 2, 2, 2, 2, 2, 0};
      int unsigned cl[8] = '{1, 1, 1, 1, 1, 1, 1, 0};
      int unsigned cv[8] = '{600, 540, 541, 728, 729, 600, 600, 600};
      for (int k = 0; k < 8; k++) begin
        cfg_p = 8'(cp[k]); cfg_q_hi = 8'(ch[k]); cfg_q_lo = 8'(cl[k]);
        vco_est_mhz = 12'(cv[k]);
        @(negedge clk);
        check(cfg_ok == exp_ok(cp[k], ch[k], cl[k], cv[k]), "R9 cfg_ok directed",
              cfg_ok, exp_ok(cp[k], ch[k], cl[k], cv[k]));
      end
    end
    for (int k = 0; k < 12; k++) begin
      cfg_p = 8'($urandom_range(0, 6));
      cfg_q_hi = 8'($urandom_range(0, 3));
      cfg_q_lo = 8'($urandom_range(0, 3));
      vco_est_mhz = 12'($urandom_range(500, 760));
      @(negedge clk);
      check(cfg_ok == exp_ok(cfg_p, cfg_q_hi, cfg_q_lo, vco_est_mhz), "R9 cfg_ok random",
            cfg_ok, exp_ok(cfg_p, cfg_q_hi, cfg_q_lo, vco_est_mhz));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule